// File: doc/BRIEF.md
# SD host interrupt status controller

This block gathers the interrupt events of an SD host controller into one level interrupt line. Short pulses from the command sequencer, the DMA engine and the card-detect logic are latched into a 32-bit raw status register. A 32-bit mask register selects which raw flags may drive the interrupt, and a global enable bit in the control register gates the line as a whole. Software acknowledges a flag by writing a one to it. The raw-status address and the masked-status address both feed the same clear path.

A separate DMA status register records transfer completion and direction. Software may clear only its low bits. A card-present bit tracks the most recent card-detect event. The insert and remove flags in the raw register never stand together.

All state is reached through a word-addressed 32-bit register port. A write takes effect at the clock edge, and reads are combinational from the current state.

Top module: `sdh_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x300, the card status register reads 0x100, and the mask, raw status, masked status and DMA status registers read 0. `irq_o` is low.
- R2: A write to the control register (address 0) stores the written value, except that bits 2, 1 and 0 always read back as 0.
- R3: The masked status register (address 2) always reads as the raw status (address 3) ANDed with the mask (address 1).
- R4: `irq_o` is a register. In each cycle it shows whether, in the previous cycle, control bit 4 was set and raw AND mask was nonzero. When bit 4 was clear it is low.
- R5: A write to address 2 or address 3 clears exactly the raw bits that are 1 in the written value. It leaves every other raw bit unchanged.
- R6: Event pulses set raw bits as follows: command done sets bit 2, no response sets bit 1, data done sets bit 3, auto-stop done sets bit 14, and DMA done sets bits 3 and 16.
- R7: A card-insert pulse sets raw bit 30, clears raw bit 31 and sets card status bit 8. A card-remove pulse sets raw bit 31, clears raw bit 30 and clears card status bit 8. When both pulses arrive in the same cycle, the removal takes effect.
- R8: DMA done sets DMA status bit 8, and also bit 0 for a transmit or bit 1 for a receive. A write to address 5 clears those of bits 9:0 that are written as 1, and never changes bits 31:10.
- R9: When an event pulse and a software clear hit the same raw bit in the same cycle, the bit ends up set.
- R10: The mask register (address 1) reads back the value last written to it. Writes to the card status register (address 4) have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address: 0 control, 1 mask, 2 masked status, 3 raw status, 4 card status, 5 DMA status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_cmd_done | input | 1 | Command completed pulse |
| ev_no_resp | input | 1 | Command got no response pulse |
| ev_data_done | input | 1 | Data transfer completed pulse |
| ev_auto_stop | input | 1 | Automatic stop command completed pulse |
| ev_dma_done | input | 1 | DMA run completed pulse |
| ev_dma_tx | input | 1 | Direction of the DMA run: 1 transmit, 0 receive |
| card_in | input | 1 | Card inserted pulse |
| card_out | input | 1 | Card removed pulse |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench builds the block with its default parameters: a 10-bit clearable field in the DMA status register, and reset values 0x300 for control and 0x100 for card status. With these values the bench reaches the boundary at bit 9/10 of the DMA status register, where a full-ones write must stop. It also observes the exact reset constants. The bench compares the interrupt line and the read data with a behavioural model on every cycle. This covers the one-cycle lag of the interrupt, same-cycle clashes between events and clears, and simultaneous insert and remove pulses.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

  localparam int DW = 32;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    SEL_GCTL  = 3'd0,
    SEL_MASK  = 3'd1,
    SEL_MSTAT = 3'd2,
    SEL_RAW   = 3'd3,
    SEL_CARD  = 3'd4,
    SEL_DMA   = 3'd5
  } reg_sel_e;

  // raw status bit positions
  localparam int RAW_NORESP = 1;
  localparam int RAW_CMD    = 2;
  localparam int RAW_DATA   = 3;
  localparam int RAW_ASTOP  = 14;
  localparam int RAW_DMA    = 16;
  localparam int RAW_INS    = 30;
  localparam int RAW_REM    = 31;

  // other bit positions
  localparam int GCTL_IEN   = 4;
  localparam int CARD_PRES  = 8;
  localparam int DMA_TX     = 0;
  localparam int DMA_RX     = 1;
  localparam int DMA_SUM    = 8;

  // set wins over clear
  function automatic logic [DW-1:0] w1c_next(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] set,
                                             input logic [DW-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [DW-1:0] masked_view(input logic [DW-1:0] raw,
                                                input logic [DW-1:0] mask);
    return raw & mask;
  endfunction

endpackage

// File: rtl/sdh_raw_status.sv
module sdh_raw_status
  import sdh_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] raw_o
);

  logic [DW-1:0] raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= w1c_next(raw_q, set_i, clr_i);
  end

  assign raw_o = raw_q;

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((raw_o & $past(set_i)) == $past(set_i)));

  assert_clear_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((raw_o & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/sdh_dma_status.sv
module sdh_dma_status
  import sdh_irq_pkg::*;
#(
  parameter int CLR_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic          tx_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] stat_o
);

  localparam logic [DW-1:0] CLR_MASK = {DW{1'b1}} >> (DW - CLR_W);

  logic [DW-1:0] stat_q;
  logic [DW-1:0] set_w;
  logic [DW-1:0] clr_w;

  always_comb begin
    set_w = '0;
    if (done_i) begin
      set_w[DMA_SUM] = 1'b1;
      if (tx_i) set_w[DMA_TX] = 1'b1;
      else      set_w[DMA_RX] = 1'b1;
    end
  end

  assign clr_w = wr_i ? (wdata_i & CLR_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= w1c_next(stat_q, set_w, clr_w);
  end

  assign stat_o = stat_q;

  assert_upper_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (stat_o[DW-1:CLR_W] == $past(stat_o[DW-1:CLR_W])));

  assert_done_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (stat_o[DMA_SUM] && (stat_o[DMA_TX] || stat_o[DMA_RX])));

endmodule

// File: rtl/sdh_irq_drive.sv
module sdh_irq_drive
  import sdh_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [DW-1:0] raw_i,
  input  logic [DW-1:0] mask_i,
  output logic          irq_o
);

  logic pend_w;
  logic irq_q;

  assign pend_w = |masked_view(raw_i, mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= en_i & pend_w;
  end

  assign irq_o = irq_q;

  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !irq_o);

  assert_irq_raised_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && ((raw_i & mask_i) != '0)) |=> irq_o);

endmodule

// File: rtl/sdh_irq_ctrl.sv
module sdh_irq_ctrl
  import sdh_irq_pkg::*;
#(
  parameter int          DMA_CLR_W = 10,
  parameter logic [31:0] GCTL_RST  = 32'h0000_0300,
  parameter logic [31:0] CARD_RST  = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_cmd_done,
  input  logic          ev_no_resp,
  input  logic          ev_data_done,
  input  logic          ev_auto_stop,
  input  logic          ev_dma_done,
  input  logic          ev_dma_tx,
  input  logic          card_in,
  input  logic          card_out,
  output logic          irq_o
);

  localparam logic [DW-1:0] SELF_CLR = 32'h0000_0007;

  logic [DW-1:0] gctl_q, mask_q, card_q;
  logic [DW-1:0] raw_w, dma_w;
  logic [DW-1:0] raw_set_w, raw_clr_w;
  logic          wr_gctl_w, wr_mask_w, wr_rawclr_w, wr_dma_w;
  logic          card_add_w, card_rm_w;

  assign wr_gctl_w   = reg_wr && (reg_addr == SEL_GCTL);
  assign wr_mask_w   = reg_wr && (reg_addr == SEL_MASK);
  assign wr_rawclr_w = reg_wr && ((reg_addr == SEL_RAW) || (reg_addr == SEL_MSTAT));
  assign wr_dma_w    = reg_wr && (reg_addr == SEL_DMA);

  // removal takes priority over a simultaneous insertion
  assign card_rm_w  = card_out;
  assign card_add_w = card_in & ~card_out;

  always_comb begin
    raw_set_w = '0;
    raw_set_w[RAW_CMD]    = ev_cmd_done;
    raw_set_w[RAW_NORESP] = ev_no_resp;
    raw_set_w[RAW_DATA]   = ev_data_done | ev_dma_done;
    raw_set_w[RAW_ASTOP]  = ev_auto_stop;
    raw_set_w[RAW_DMA]    = ev_dma_done;
    raw_set_w[RAW_INS]    = card_add_w;
    raw_set_w[RAW_REM]    = card_rm_w;
  end

  always_comb begin
    raw_clr_w = wr_rawclr_w ? reg_wdata : '0;
    if (card_add_w) raw_clr_w[RAW_REM] = 1'b1;
    if (card_rm_w)  raw_clr_w[RAW_INS] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl_q <= GCTL_RST;
      mask_q <= '0;
      card_q <= CARD_RST;
    end else begin
      if (wr_gctl_w) gctl_q <= reg_wdata & ~SELF_CLR;
      if (wr_mask_w) mask_q <= reg_wdata;
      if (card_rm_w)       card_q[CARD_PRES] <= 1'b0;
      else if (card_add_w) card_q[CARD_PRES] <= 1'b1;
    end
  end

  sdh_raw_status raw_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (raw_set_w),
    .clr_i (raw_clr_w),
    .raw_o (raw_w)
  );

  sdh_dma_status #(.CLR_W(DMA_CLR_W)) dma_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (ev_dma_done),
    .tx_i    (ev_dma_tx),
    .wr_i    (wr_dma_w),
    .wdata_i (reg_wdata),
    .stat_o  (dma_w)
  );

  sdh_irq_drive irq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (gctl_q[GCTL_IEN]),
    .raw_i  (raw_w),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (reg_addr)
      SEL_GCTL:  reg_rdata = gctl_q;
      SEL_MASK:  reg_rdata = mask_q;
      SEL_MSTAT: reg_rdata = masked_view(raw_w, mask_q);
      SEL_RAW:   reg_rdata = raw_w;
      SEL_CARD:  reg_rdata = card_q;
      SEL_DMA:   reg_rdata = dma_w;
      default:   reg_rdata = '0;
    endcase
  end

  assert_card_insert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (card_in && !card_out) |=> (raw_w[RAW_INS] && !raw_w[RAW_REM] && card_q[CARD_PRES]));

  assert_card_remove_R7: assert property (@(posedge clk) disable iff (!rst_n)
    card_out |=> (raw_w[RAW_REM] && !raw_w[RAW_INS] && !card_q[CARD_PRES]));

  assert_selfclr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gctl_w |=> (gctl_q[2:0] == 3'b000));

endmodule

// File: tb/sdh_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sdh_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ev_cmd_done = 0, ev_no_resp = 0, ev_data_done = 0, ev_auto_stop = 0;
  logic ev_dma_done = 0, ev_dma_tx = 0, card_in = 0, card_out = 0;
  logic irq_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m_gctl = 32'h300, m_mask = 0, m_raw = 0, m_card = 32'h100, m_dma = 0;
  logic        m_irq = 0;

  always #2.5 clk = ~clk;

  sdh_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_cmd_done(ev_cmd_done), .ev_no_resp(ev_no_resp), .ev_data_done(ev_data_done),
    .ev_auto_stop(ev_auto_stop), .ev_dma_done(ev_dma_done), .ev_dma_tx(ev_dma_tx),
    .card_in(card_in), .card_out(card_out), .irq_o(irq_o)
  );

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_gctl;
      3'd1: return m_mask;
      3'd2: return m_raw & m_mask;
      3'd3: return m_raw;
      3'd4: return m_card;
      3'd5: return m_dma;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step();
    m_irq = m_gctl[4] && ((m_raw & m_mask) != 0);
    if (reg_wr) begin
      case (reg_addr)
        3'd0: m_gctl = reg_wdata & 32'hFFFF_FFF8;
        3'd1: m_mask = reg_wdata;
        3'd2, 3'd3: m_raw = m_raw & ~reg_wdata;
        3'd5: m_dma = m_dma & ~(reg_wdata & 32'h3FF);
        default: ;
      endcase
    end
    if (card_out) begin
      m_raw[31] = 1; m_raw[30] = 0; m_card[8] = 0;
    end else if (card_in) begin
      m_raw[30] = 1; m_raw[31] = 0; m_card[8] = 1;
    end
    if (ev_cmd_done)  m_raw[2] = 1;
    if (ev_no_resp)   m_raw[1] = 1;
    if (ev_data_done) m_raw[3] = 1;
    if (ev_auto_stop) m_raw[14] = 1;
    if (ev_dma_done) begin
      m_raw[3] = 1; m_raw[16] = 1;
      m_dma[8] = 1;
      if (ev_dma_tx) m_dma[0] = 1; else m_dma[1] = 1;
    end
  endtask

  task automatic cyc(input string req);
    logic [31:0] exp_rd;
    @(posedge clk);
    model_step();
    #1;
    checks++;
    if (irq_o !== m_irq) begin
      failures++;
      $display("FAIL %s irq_o actual=%0b expected=%0b t=%0t", req, irq_o, m_irq, $time);
    end
    exp_rd = model_read(reg_addr);
    checks++;
    if (reg_rdata !== exp_rd) begin
      failures++;
      $display("FAIL %s rdata[addr %0d] actual=%h expected=%h t=%0t",
               req, reg_addr, reg_rdata, exp_rd, $time);
    end
    reg_wr = 0; ev_cmd_done = 0; ev_no_resp = 0; ev_data_done = 0; ev_auto_stop = 0;
    ev_dma_done = 0; ev_dma_tx = 0; card_in = 0; card_out = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string req);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc(req);
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    reg_addr = a;
    cyc(req);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset values
    for (int a = 0; a < 6; a++) rd(3'(a), "R1");
    // R2 self-clearing control bits
    wr(3'd0, 32'hFFFF_FFFF, "R2");
    rd(3'd0, "R2");
    wr(3'd0, 32'h0000_0010, "R2");
    // R10 mask read/write
    wr(3'd1, 32'h0000_4004, "R10");
    rd(3'd1, "R10");
    // R6 events, R3 masked view, R4 lag
    ev_cmd_done = 1; rd(3'd3, "R6");
    rd(3'd2, "R3");
    rd(3'd2, "R4");
    ev_no_resp = 1; rd(3'd3, "R6");
    ev_auto_stop = 1; ev_data_done = 1; rd(3'd3, "R6");
    rd(3'd2, "R3");
    // R5 clear through masked and raw addresses
    wr(3'd2, 32'h0000_0004, "R5");
    rd(3'd3, "R5");
    rd(3'd2, "R4");
    wr(3'd3, 32'h0000_4000, "R5");
    rd(3'd3, "R4");
    rd(3'd3, "R4");
    wr(3'd3, 32'hFFFF_FFFF, "R5");
    rd(3'd3, "R5");
    // R7 card events
    card_in = 1; rd(3'd4, "R7");
    rd(3'd3, "R7");
    card_out = 1; rd(3'd4, "R7");
    rd(3'd3, "R7");
    card_in = 1; rd(3'd3, "R7");
    card_in = 1; card_out = 1; rd(3'd4, "R7");
    rd(3'd3, "R7");
    card_in = 1; rd(3'd4, "R7");
    // R10 card status not writable
    wr(3'd4, 32'h0000_0000, "R10");
    rd(3'd4, "R10");
    wr(3'd4, 32'hFFFF_FFFF, "R10");
    rd(3'd4, "R10");
    // R8 DMA status
    ev_dma_done = 1; ev_dma_tx = 1; rd(3'd5, "R8");
    ev_dma_done = 1; ev_dma_tx = 0; rd(3'd5, "R8");
    rd(3'd3, "R6");
    wr(3'd5, 32'h0000_0001, "R8");
    rd(3'd5, "R8");
    wr(3'd5, 32'hFFFF_FFFF, "R8");
    rd(3'd5, "R8");
    // R4 masked DMA flag drives irq, then global disable holds it low
    wr(3'd1, 32'h0001_0000, "R4");
    rd(3'd2, "R4");
    rd(3'd2, "R4");
    wr(3'd0, 32'h0000_0000, "R4");
    rd(3'd0, "R4");
    rd(3'd0, "R4");
    wr(3'd0, 32'h0000_0010, "R4");
    rd(3'd0, "R4");
    rd(3'd0, "R4");
    // R9 event beats clear in the same cycle
    ev_cmd_done = 1; wr(3'd3, 32'hFFFF_FFFF, "R9");
    rd(3'd3, "R9");
    ev_dma_done = 1; ev_dma_tx = 1; wr(3'd5, 32'hFFFF_FFFF, "R9");
    rd(3'd5, "R9");
    ev_no_resp = 1; wr(3'd2, 32'h0000_0002, "R9");
    rd(3'd3, "R9");
    rd(3'd3, "R3");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule